// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block keeps the internal word address for a 2048-byte byte-wide memory behind a serial bus slave. The protocol controller loads a starting address, then steps the counter once per byte moved. A write burst stays inside one 16-byte page: only the low four address bits count, so a burst that runs past the last byte of a page continues at the first byte of that same page. A read burst counts across the whole address space and runs from the top address back to zero. The address reached after any transfer is kept, so the next current-address read starts where the previous operation stopped.

The block also gathers the data bytes of a page write. Each byte is placed in the buffer slot chosen by the low address bits and marks that slot valid. When the controller sees a proper stop it asks for a commit, and the block issues one registered commit word to the array: the page row, all 16 data slots and a byte mask. A burst that ends without a proper stop is thrown away with a discard request, and nothing is committed.

Top module: `page_wrap_addr_ctr`

## Requirements
- R1: In the cycle after `rst_n` is sampled low, `cur_addr` is 0, `buf_vld` is all zeros and `cmt_en` is 0.
- R2: When `ld_en` is high at a clock edge, `cur_addr` equals `ld_addr` after that edge, even if `inc_en` is high in the same cycle.
- R3: An increment with `inc_is_wr` = 1 adds one to `cur_addr[3:0]` modulo 16 and keeps `cur_addr[10:4]` unchanged (0x12F steps to 0x120).
- R4: An increment with `inc_is_wr` = 0 adds one to all 11 bits of `cur_addr`, carrying into the row bits (0x0FF steps to 0x100) and wrapping from 0x7FF to 0x000.
- R5: With neither `ld_en` nor `inc_en` high, `cur_addr` holds its value; commits and discards do not change it.
- R6: When `wdat_vld` is high, `wdat` is stored in slot `cur_addr[3:0]` (bits `[8*s +: 8]` of `buf_data`) and bit `s` of `buf_vld` is set; a later byte to the same slot replaces the earlier one, so a burst longer than 16 bytes keeps the newest byte in each slot.
- R7: A `commit_req` with at least one valid slot makes `cmt_en` high for exactly the next cycle, with `cmt_data` equal to the buffer contents, `cmt_mask` equal to the valid flags and `cmt_row` equal to `cur_addr[10:4]` at the last buffered byte; `buf_vld` is all zeros in that same cycle.
- R8: A `commit_req` while no slot is valid produces no `cmt_en` pulse.
- R9: `discard` clears all valid flags with no `cmt_en` pulse, and takes precedence over a `commit_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Load `ld_addr` into the counter |
| ld_addr | input | 11 | Address to load |
| inc_en | input | 1 | Advance the counter by one byte |
| inc_is_wr | input | 1 | 1: page-wrapping write step, 0: full-range read step |
| wdat_vld | input | 1 | Store `wdat` in the page buffer |
| wdat | input | 8 | Write data byte |
| commit_req | input | 1 | Send the buffered page to the array |
| discard | input | 1 | Drop the buffered page |
| cur_addr | output | 11 | Current word address |
| buf_data | output | 128 | Page buffer, slot s in bits `[8*s +: 8]` |
| buf_vld | output | 16 | Valid flag per buffer slot |
| cmt_en | output | 1 | One-cycle commit strobe to the array |
| cmt_row | output | 7 | Page row of the commit |
| cmt_data | output | 128 | Commit data, same slot layout as `buf_data` |
| cmt_mask | output | 16 | Slots to be written by the commit |

## Verification
The bench walks the counter across the write-step page edge at 0x12F, the read-step carry at 0x0FF and the full wrap at 0x7FF; a counter that carried write steps into the row would land on the next page, and one that masked read steps would never leave the page. It drives an 18-byte burst starting two slots before the page end, so a buffer that kept the first byte or dropped the overflow would show stale data in slots 14 and 15. It checks a partial page mask, that load beats increment in the same cycle, and that discard, discard with commit, and an empty commit all leave `cmt_en` low; a design committing on those would write the array with stale data.

// File: rtl/pwc_pkg.sv
// Shared types for the page-wrapping address counter.
package pwc_pkg;
    // Kind of address step requested by the protocol controller.
    typedef enum logic {
        STEP_RD = 1'b0,
        STEP_WR = 1'b1
    } step_kind_e;
endpackage

// File: rtl/pwc_addr_step.sv
// Next-address logic. Load wins over increment; a write step counts
// only the low PAGE_W bits, a read step counts the full address.
// Assumes ld_addr and cur are ADDR_W bits wide and PAGE_W < ADDR_W.
module pwc_addr_step
    import pwc_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              inc_en,
    input  step_kind_e        kind,
    output logic [ADDR_W-1:0] nxt
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    logic [ROW_W-1:0]  row_keep;
    logic [PAGE_W-1:0] col_step;

    assign row_keep = cur[ADDR_W-1:PAGE_W];
    assign col_step = cur[PAGE_W-1:0] + PAGE_W'(1);

    // Select the address for the next cycle.
    always_comb begin
        nxt = cur;
        if (ld_en) begin
            nxt = ld_addr;
        end else if (inc_en) begin
            if (kind == STEP_WR) begin
                nxt = {row_keep, col_step};
            end else begin
                nxt = cur + ADDR_W'(1);
            end
        end
    end
endmodule

// File: rtl/pwc_page_buf.sv
// Page write buffer: one data byte and one valid flag per slot, plus
// the row of the bytes held. A write to a slot beats a clear in the
// same cycle, so that byte survives into the next page.
// Assumes slot index is the low address bits of the byte written.
module pwc_page_buf #(
    parameter int NSLOT  = 16,
    parameter int DATA_W = 8,
    parameter int ROW_W  = 7,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SLOT_W-1:0]         wr_slot,
    input  logic [DATA_W-1:0]         wr_byte,
    input  logic [ROW_W-1:0]          wr_row,
    input  logic                      clr,
    output logic [NSLOT*DATA_W-1:0]   data,
    output logic [NSLOT-1:0]          vld,
    output logic [ROW_W-1:0]          row
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_slot == SLOT_W'(s));

        // Hold one slot's byte and valid flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[s]                  <= 1'b0;
                data[s*DATA_W +: DATA_W] <= '0;
            end else if (hit) begin
                vld[s]                  <= 1'b1;
                data[s*DATA_W +: DATA_W] <= wr_byte;
            end else if (clr) begin
                vld[s]                  <= 1'b0;
            end
        end
    end

    // Remember the page row of the most recent byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (wr_en) begin
            row <= wr_row;
        end
    end
endmodule

// File: rtl/pwc_commit_stage.sv
// Registers one commit word for the array and pulses its strobe for a
// single cycle. Assumes fire is already qualified by the caller.
module pwc_commit_stage #(
    parameter int NSLOT  = 16,
    parameter int DATA_W = 8,
    parameter int ROW_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  logic [ROW_W-1:0]        in_row,
    input  logic [NSLOT*DATA_W-1:0] in_data,
    input  logic [NSLOT-1:0]        in_mask,
    output logic                    cmt_en,
    output logic [ROW_W-1:0]        cmt_row,
    output logic [NSLOT*DATA_W-1:0] cmt_data,
    output logic [NSLOT-1:0]        cmt_mask
);
    // Capture the buffered page when a commit fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmt_en   <= 1'b0;
            cmt_row  <= '0;
            cmt_data <= '0;
            cmt_mask <= '0;
        end else begin
            cmt_en <= fire;
            if (fire) begin
                cmt_row  <= in_row;
                cmt_data <= in_data;
                cmt_mask <= in_mask;
            end
        end
    end
endmodule

// File: rtl/page_wrap_addr_ctr.sv
// Word address counter with page write buffer. Holds the current
// address, steps it with page wrap for writes and full wrap for reads,
// gathers page write bytes and hands them to the array on commit.
// Assumes the protocol controller raises commit_req only on a proper
// stop and discard on any other end of a write burst.
module page_wrap_addr_ctr
    import pwc_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8,
    localparam int ROW_W = ADDR_W - PAGE_W,
    localparam int NSLOT = 1 << PAGE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_en,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic                    inc_en,
    input  logic                    inc_is_wr,
    input  logic                    wdat_vld,
    input  logic [DATA_W-1:0]       wdat,
    input  logic                    commit_req,
    input  logic                    discard,
    output logic [ADDR_W-1:0]       cur_addr,
    output logic [NSLOT*DATA_W-1:0] buf_data,
    output logic [NSLOT-1:0]        buf_vld,
    output logic                    cmt_en,
    output logic [ROW_W-1:0]        cmt_row,
    output logic [NSLOT*DATA_W-1:0] cmt_data,
    output logic [NSLOT-1:0]        cmt_mask
);
    step_kind_e        kind;
    logic [ADDR_W-1:0] addr_nxt;
    logic [ROW_W-1:0]  buf_row;
    logic              fire;

    assign kind = inc_is_wr ? STEP_WR : STEP_RD;
    assign fire = commit_req && !discard && (|buf_vld);

    pwc_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
        .cur     (cur_addr),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .inc_en  (inc_en),
        .kind    (kind),
        .nxt     (addr_nxt)
    );

    // Current address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else begin
            cur_addr <= addr_nxt;
        end
    end

    pwc_page_buf #(.NSLOT(NSLOT), .DATA_W(DATA_W), .ROW_W(ROW_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wdat_vld),
        .wr_slot (cur_addr[PAGE_W-1:0]),
        .wr_byte (wdat),
        .wr_row  (cur_addr[ADDR_W-1:PAGE_W]),
        .clr     (commit_req || discard),
        .data    (buf_data),
        .vld     (buf_vld),
        .row     (buf_row)
    );

    pwc_commit_stage #(.NSLOT(NSLOT), .DATA_W(DATA_W), .ROW_W(ROW_W)) u_cmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .in_row   (buf_row),
        .in_data  (buf_data),
        .in_mask  (buf_vld),
        .cmt_en   (cmt_en),
        .cmt_row  (cmt_row),
        .cmt_data (cmt_data),
        .cmt_mask (cmt_mask)
    );
endmodule

// File: rtl/pwc_checker.sv
// Property checker for page_wrap_addr_ctr, attached by bind.
module pwc_checker #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4,
    parameter int NSLOT  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_en,
    input logic              inc_en,
    input logic              inc_is_wr,
    input logic              wdat_vld,
    input logic              commit_req,
    input logic              discard,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [NSLOT-1:0]  buf_vld,
    input logic              cmt_en
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cur_addr == '0 && buf_vld == '0 && !cmt_en));

    a_r3_write_step_stays_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && inc_is_wr && !ld_en) |=>
            (cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W]) &&
             cur_addr[PAGE_W-1:0] == PAGE_W'($past(cur_addr[PAGE_W-1:0]) + 1'b1)));

    a_r4_read_step_full_range: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !inc_is_wr && !ld_en) |=>
            (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !inc_en) |=> $stable(cur_addr));

    a_r7_strobe_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_en |-> ($past(commit_req) && !$past(discard)));

    a_r7_flags_clear_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !wdat_vld) |=> (buf_vld == '0));

    a_r8_empty_commit_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && buf_vld == '0) |=> !cmt_en);

    a_r9_discard_drops_page: assert property (@(posedge clk) disable iff (!rst_n)
        (discard && !wdat_vld) |=> (buf_vld == '0 && !cmt_en));
endmodule

bind page_wrap_addr_ctr pwc_checker #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .NSLOT  (NSLOT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .inc_en     (inc_en),
    .inc_is_wr  (inc_is_wr),
    .wdat_vld   (wdat_vld),
    .commit_req (commit_req),
    .discard    (discard),
    .cur_addr   (cur_addr),
    .buf_vld    (buf_vld),
    .cmt_en     (cmt_en)
);

// File: tb/sim_page_wrap_addr_ctr.sv
`timescale 1ns/100ps
module sim_page_wrap_addr_ctr;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         ld_en, inc_en, inc_is_wr, wdat_vld, commit_req, discard;
    logic [10:0]  ld_addr;
    logic [7:0]   wdat;
    logic [10:0]  cur_addr;
    logic [127:0] buf_data, cmt_data;
    logic [15:0]  buf_vld, cmt_mask;
    logic         cmt_en;
    logic [6:0]   cmt_row;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    page_wrap_addr_ctr u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .inc_en(inc_en), .inc_is_wr(inc_is_wr), .wdat_vld(wdat_vld),
        .wdat(wdat), .commit_req(commit_req), .discard(discard),
        .cur_addr(cur_addr), .buf_data(buf_data), .buf_vld(buf_vld),
        .cmt_en(cmt_en), .cmt_row(cmt_row), .cmt_data(cmt_data),
        .cmt_mask(cmt_mask)
    );

    // Vector: {op[1:0], argument[10:0], expected cur_addr[10:0]}
    // op 0 idle, 1 load, 2 write step, 3 read step.
    localparam logic [23:0] VEC [14] = '{
        {2'd1, 11'h12D, 11'h12D},
        {2'd2, 11'h000, 11'h12E},
        {2'd2, 11'h000, 11'h12F},
        {2'd2, 11'h000, 11'h120},
        {2'd0, 11'h000, 11'h120},
        {2'd1, 11'h7FE, 11'h7FE},
        {2'd3, 11'h000, 11'h7FF},
        {2'd3, 11'h000, 11'h000},
        {2'd1, 11'h0FF, 11'h0FF},
        {2'd3, 11'h000, 11'h100},
        {2'd1, 11'h7FF, 11'h7FF},
        {2'd2, 11'h000, 11'h7F0},
        {2'd0, 11'h000, 11'h7F0},
        {2'd3, 11'h000, 11'h7F1}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ld_en = 0; ld_addr = '0; inc_en = 0; inc_is_wr = 0;
        wdat_vld = 0; wdat = '0; commit_req = 0; discard = 0;
    endtask

    // Apply the inputs already set for one edge, then sample at negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] exp_slot [16];
        logic [127:0] exp_flat;
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 addr", 128'(cur_addr), 128'h0);
        chk("R1 vld", 128'(buf_vld), 128'h0);
        chk("R1 cmt_en", 128'(cmt_en), 128'h0);
        rst_n = 1;

        // Address vector table: R2 load, R3 write step, R4 read step, R5 hold
        for (int i = 0; i < 14; i++) begin
            case (VEC[i][23:22])
                2'd1: begin ld_en = 1; ld_addr = VEC[i][21:11]; end
                2'd2: begin inc_en = 1; inc_is_wr = 1; end
                2'd3: begin inc_en = 1; inc_is_wr = 0; end
                default: ;
            endcase
            step();
            chk($sformatf("R2/R3/R4/R5 vector %0d", i), 128'(cur_addr), 128'(VEC[i][10:0]));
        end

        // R2: load wins over a same-cycle increment
        ld_en = 1; ld_addr = 11'h355; inc_en = 1; inc_is_wr = 0;
        step();
        chk("R2 load priority", 128'(cur_addr), 128'h355);

        // R6 / R7: 18-byte burst from slot 14 wraps and overwrites
        ld_en = 1; ld_addr = 11'h3AE;
        step();
        for (int s = 0; s < 16; s++) exp_slot[s] = 8'h00;
        for (int i = 0; i < 18; i++) begin
            wdat_vld = 1; wdat = 8'h40 + 8'(i); inc_en = 1; inc_is_wr = 1;
            exp_slot[(14 + i) % 16] = 8'h40 + 8'(i);
            step();
        end
        exp_flat = '0;
        for (int s = 0; s < 16; s++) exp_flat[s*8 +: 8] = exp_slot[s];
        chk("R3 burst end addr", 128'(cur_addr), 128'h3A0);
        chk("R6 full mask", 128'(buf_vld), 128'hFFFF);
        chk("R6 overwritten data", buf_data, exp_flat);
        commit_req = 1;
        step();
        chk("R7 cmt_en", 128'(cmt_en), 128'h1);
        chk("R7 cmt_row", 128'(cmt_row), 128'h3A);
        chk("R7 cmt_mask", 128'(cmt_mask), 128'hFFFF);
        chk("R7 cmt_data", cmt_data, exp_flat);
        chk("R7 flags cleared", 128'(buf_vld), 128'h0);
        chk("R5 addr kept on commit", 128'(cur_addr), 128'h3A0);
        step();
        chk("R7 single pulse", 128'(cmt_en), 128'h0);

        // R7: partial page of three bytes at slots 5..7
        ld_en = 1; ld_addr = 11'h105;
        step();
        for (int i = 0; i < 3; i++) begin
            wdat_vld = 1; wdat = 8'hA0 + 8'(i); inc_en = 1; inc_is_wr = 1;
            step();
        end
        commit_req = 1;
        step();
        chk("R7 partial cmt_en", 128'(cmt_en), 128'h1);
        chk("R7 partial mask", 128'(cmt_mask), 128'h00E0);
        chk("R7 partial row", 128'(cmt_row), 128'h10);
        chk("R7 partial bytes", 128'(cmt_data[63:40]), 128'hA2A1A0);
        chk("R5 next current address", 128'(cur_addr), 128'h108);

        // R9: discard drops bytes without a commit
        for (int i = 0; i < 2; i++) begin
            wdat_vld = 1; wdat = 8'h11; inc_en = 1; inc_is_wr = 1;
            step();
        end
        chk("R6 two bytes buffered", 128'(buf_vld), 128'h0300);
        discard = 1;
        step();
        chk("R9 discard clears", 128'(buf_vld), 128'h0);
        chk("R9 no strobe", 128'(cmt_en), 128'h0);

        // R8: commit with an empty buffer
        commit_req = 1;
        step();
        chk("R8 empty commit", 128'(cmt_en), 128'h0);

        // R9: discard beats commit in the same cycle
        wdat_vld = 1; wdat = 8'h22;
        step();
        discard = 1; commit_req = 1;
        step();
        chk("R9 discard priority strobe", 128'(cmt_en), 128'h0);
        chk("R9 discard priority flags", 128'(buf_vld), 128'h0);

        // R1: reset in mid-operation
        wdat_vld = 1; wdat = 8'h33;
        step();
        rst_n = 0;
        step();
        rst_n = 1;
        chk("R1 reset addr", 128'(cur_addr), 128'h0);
        chk("R1 reset flags", 128'(buf_vld), 128'h0);

        summary();
    end
endmodule